// File: doc/BRIEF.md
# Bit Set/Clear Register Bank

This block is a small bank of peripheral control registers on a simple synchronous bus. Every register in the bank can be reached through three word addresses. The first address turns bits on. The second turns bits off. The third returns the stored value. A write to the set or clear address only changes the bits whose write-data bit is one. Software can therefore flip single control bits without a read-modify-write sequence, and two agents can each change their own bits without racing each other.

A plain mode register sits directly after the aliased registers. Every write to it replaces the whole word, so the two access styles can be compared on the same bus. The bank decodes only the low address bits of its 16 KB window; the interconnect selects the window. Register contents drive the peripheral logic continuously through flat output buses. Read data is registered, with one cycle of latency.

Top module: `sab_regbank`

## Requirements
- R1: While reset is asserted, every aliased register clears to zero, the mode register takes its reset value (zero by default) and the read data is zero.
- R2: Addresses are byte addresses, and only word-aligned addresses (bits [1:0] zero) are decoded. Register i has its set address at 12*i, its clear address at 12*i+4 and its read address at 12*i+8. The mode register is at 12*NUM_REGS. With four registers these are 0x00/0x04/0x08, 0x0C/0x10/0x14, 0x18/0x1C/0x20 and 0x24/0x28/0x2C, with the mode register at 0x30.
- R3: A write to the set address of register i drives to one each bit whose write-data bit is one and leaves the other bits unchanged. A write of zero changes nothing.
- R4: A write to the clear address of register i drives to zero each bit whose write-data bit is one and leaves the other bits unchanged.
- R5: A read strobe at the read address of register i returns that register's stored value on the bus read data in the cycle after the strobe.
- R6: A set or clear write takes effect on the clock edge that samples the write strobe, so a read issued in the next cycle returns the new value. A read and a write in the same cycle return the value from before the write.
- R7: Reads of a set or clear address return zero. Writes to a read address change no register.
- R8: A write to the mode register replaces all of its bits. A read at the same address returns the stored value.
- R9: An access to an undecoded address reads as zero and changes no register. Undecoded addresses are those above the mode register and any address with bits [1:0] non-zero.
- R10: Read data is zero in any cycle that follows a cycle without a read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address inside the bank window |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data, used as a bit mask on the set and clear addresses |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Registered read data |
| reg_out | output | NUM_REGS*DATA_W | Aliased register contents; register i occupies bits [i*DATA_W +: DATA_W] |
| mode_out | output | DATA_W | Mode register contents |

## Verification
The bound checker runs on every cycle. It checks the set and clear updates of each register against its previous value, checks that a register holds whenever none of its own write addresses is hit, and checks that the read data matches the addressed register. It also checks that set/clear addresses, undecoded addresses and idle cycles return zero, and that reset clears the bank. Only the bench scenarios can show sequences that run over several accesses. Examples are a value built up by several set and clear writes and then read back, back-to-back write-then-read latency, misaligned addresses that would otherwise alias onto a live register, and a reset in the middle of operation that wipes a populated bank.

// File: rtl/sab_pkg.sv
package sab_pkg;

   // Words per aliased register: set, clear, read
   localparam int unsigned ALIAS_WORDS = 3;

   typedef enum logic [1:0] {
      SLOT_SET  = 2'd0,
      SLOT_CLR  = 2'd1,
      SLOT_READ = 2'd2
   } slot_e;

   // Word index of a given slot of register idx
   function automatic int unsigned slot_word(int unsigned idx, slot_e slot);
      return idx * ALIAS_WORDS + int'(slot);
   endfunction

endpackage

// File: rtl/sab_decode.sv
module sab_decode
   import sab_pkg::*;
#(
   parameter int unsigned ADDR_W   = 14,
   parameter int unsigned NUM_REGS = 4,
   parameter bit          HAS_MODE = 1'b1
) (
   input  logic [ADDR_W-1:0]   addr,
   output logic [NUM_REGS-1:0] hit_set,
   output logic [NUM_REGS-1:0] hit_clr,
   output logic [NUM_REGS-1:0] hit_read,
   output logic                hit_mode
);

   localparam int unsigned WORD_W = ADDR_W - 2;

   logic              aligned;
   logic [WORD_W-1:0] word;

   assign aligned = (addr[1:0] == 2'b00);
   assign word    = addr[ADDR_W-1:2];

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
      assign hit_set[i]  = aligned && (word == WORD_W'(slot_word(i, SLOT_SET)));
      assign hit_clr[i]  = aligned && (word == WORD_W'(slot_word(i, SLOT_CLR)));
      assign hit_read[i] = aligned && (word == WORD_W'(slot_word(i, SLOT_READ)));
   end

   if (HAS_MODE) begin : g_mode_dec
      assign hit_mode = aligned && (word == WORD_W'(NUM_REGS * ALIAS_WORDS));
   end else begin : g_no_mode_dec
      assign hit_mode = 1'b0;
   end

endmodule

// File: rtl/sab_alias_reg.sv
module sab_alias_reg #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_en,
   input  logic              clr_en,
   input  logic [DATA_W-1:0] mask,
   output logic [DATA_W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= '0;
      else if (set_en) q <= q | mask;
      else if (clr_en) q <= q & ~mask;
   end

endmodule

// File: rtl/sab_plain_reg.sv
module sab_plain_reg #(
   parameter int unsigned       DATA_W    = 32,
   parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= RESET_VAL;
      else if (wr_en) q <= wdata;
   end

endmodule

// File: rtl/sab_read_mux.sv
module sab_read_mux #(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned NUM_REGS = 4
) (
   input  logic [NUM_REGS-1:0]        sel_read,
   input  logic                       sel_mode,
   input  logic [NUM_REGS*DATA_W-1:0] regs,
   input  logic [DATA_W-1:0]          mode_val,
   output logic [DATA_W-1:0]          data
);

   // AND-OR tree: decoder selects are mutually exclusive
   logic [NUM_REGS:0][DATA_W-1:0] acc;

   assign acc[0] = sel_mode ? mode_val : '0;

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_or
      assign acc[i+1] = acc[i] | (sel_read[i] ? regs[i*DATA_W +: DATA_W] : '0);
   end

   assign data = acc[NUM_REGS];

endmodule

// File: rtl/sab_regbank.sv
module sab_regbank #(
   parameter int unsigned       DATA_W     = 32,
   parameter int unsigned       NUM_REGS   = 4,
   parameter int unsigned       ADDR_W     = 14,
   parameter bit                HAS_MODE   = 1'b1,
   parameter logic [DATA_W-1:0] MODE_RESET = '0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [ADDR_W-1:0]          bus_addr,
   input  logic                       bus_we,
   input  logic [DATA_W-1:0]          bus_wdata,
   input  logic                       bus_re,
   output logic [DATA_W-1:0]          bus_rdata,
   output logic [NUM_REGS*DATA_W-1:0] reg_out,
   output logic [DATA_W-1:0]          mode_out
);

   localparam int unsigned MAP_WORDS = NUM_REGS * sab_pkg::ALIAS_WORDS + (HAS_MODE ? 1 : 0);
   localparam int unsigned MAP_BYTES = MAP_WORDS * 4;

   // Elaboration-time parameter checks
   if (DATA_W < 1 || DATA_W > 32) begin : g_bad_width
      $error("sab_regbank: DATA_W must be 1..32");
   end
   if (NUM_REGS < 1) begin : g_bad_count
      $error("sab_regbank: NUM_REGS must be at least 1");
   end
   if (ADDR_W < 3 || ADDR_W > 30) begin : g_bad_addr
      $error("sab_regbank: ADDR_W must be 3..30");
   end
   if (MAP_BYTES > (64'd1 << ADDR_W)) begin : g_bad_map
      $error("sab_regbank: register map does not fit the address window");
   end

   logic [NUM_REGS-1:0] hit_set, hit_clr, hit_read;
   logic                hit_mode;
   logic [DATA_W-1:0]   rd_next;

   sab_decode #(
      .ADDR_W   (ADDR_W),
      .NUM_REGS (NUM_REGS),
      .HAS_MODE (HAS_MODE)
   ) u_decode (
      .addr     (bus_addr),
      .hit_set  (hit_set),
      .hit_clr  (hit_clr),
      .hit_read (hit_read),
      .hit_mode (hit_mode)
   );

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      sab_alias_reg #(
         .DATA_W (DATA_W)
      ) u_reg (
         .clk    (clk),
         .rst_n  (rst_n),
         .set_en (bus_we && hit_set[i]),
         .clr_en (bus_we && hit_clr[i]),
         .mask   (bus_wdata),
         .q      (reg_out[i*DATA_W +: DATA_W])
      );
   end

   if (HAS_MODE) begin : g_mode
      sab_plain_reg #(
         .DATA_W    (DATA_W),
         .RESET_VAL (MODE_RESET)
      ) u_mode (
         .clk   (clk),
         .rst_n (rst_n),
         .wr_en (bus_we && hit_mode),
         .wdata (bus_wdata),
         .q     (mode_out)
      );
   end else begin : g_mode_const
      assign mode_out = MODE_RESET;
   end

   sab_read_mux #(
      .DATA_W   (DATA_W),
      .NUM_REGS (NUM_REGS)
   ) u_rmux (
      .sel_read (hit_read),
      .sel_mode (hit_mode),
      .regs     (reg_out),
      .mode_val (mode_out),
      .data     (rd_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_re) bus_rdata <= rd_next;
      else             bus_rdata <= '0;
   end

endmodule

// File: rtl/sab_regbank_chk.sv
module sab_regbank_chk #(
   parameter int unsigned       DATA_W     = 32,
   parameter int unsigned       NUM_REGS   = 4,
   parameter int unsigned       ADDR_W     = 14,
   parameter bit                HAS_MODE   = 1'b1,
   parameter logic [DATA_W-1:0] MODE_RESET = '0
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic [ADDR_W-1:0]          bus_addr,
   input logic                       bus_we,
   input logic [DATA_W-1:0]          bus_wdata,
   input logic                       bus_re,
   input logic [DATA_W-1:0]          bus_rdata,
   input logic [NUM_REGS*DATA_W-1:0] reg_out,
   input logic [DATA_W-1:0]          mode_out
);

   localparam int unsigned LAST_WORD = NUM_REGS * 3 - (HAS_MODE ? 0 : 1);

   logic        al;
   logic [31:0] wrd;
   assign al  = (bus_addr[1:0] == 2'b00);
   assign wrd = 32'(bus_addr[ADDR_W-1:2]);

   // R1: reset clears bank and read data
   a_r1_reset_clear: assert property (@(posedge clk)
      !rst_n |=> (reg_out == '0 && bus_rdata == '0 && mode_out == MODE_RESET));

   // R10: no read strobe, zero read data
   a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_re |=> bus_rdata == '0);

   // R9: undecoded addresses read zero
   a_r9_undecoded_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_re && (!al || wrd > LAST_WORD)) |=> bus_rdata == '0);

   // R7: set and clear addresses read zero
   a_r7_alias_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_re && al && wrd < 32'(NUM_REGS * 3) && (wrd % 3) != 2) |=> bus_rdata == '0);

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_chk
      // R3: set alias ORs in the mask
      a_r3_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_we && al && wrd == 32'(3*i)) |=>
         reg_out[i*DATA_W +: DATA_W] == ($past(reg_out[i*DATA_W +: DATA_W]) | $past(bus_wdata)));

      // R4: clear alias removes the mask bits
      a_r4_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_we && al && wrd == 32'(3*i+1)) |=>
         reg_out[i*DATA_W +: DATA_W] == ($past(reg_out[i*DATA_W +: DATA_W]) & ~$past(bus_wdata)));

      // R7 / R9: no own set/clear write, register holds
      a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
         !(bus_we && al && (wrd == 32'(3*i) || wrd == 32'(3*i+1))) |=>
         $stable(reg_out[i*DATA_W +: DATA_W]));

      // R5: read alias returns stored value next cycle
      a_r5_read_value: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_re && al && wrd == 32'(3*i+2)) |=>
         bus_rdata == $past(reg_out[i*DATA_W +: DATA_W]));
   end

   if (HAS_MODE) begin : g_mode_chk
      // R8: mode write replaces the whole word
      a_r8_mode_replace: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_we && al && wrd == 32'(NUM_REGS*3)) |=> mode_out == $past(bus_wdata));
   end

endmodule

bind sab_regbank sab_regbank_chk #(
   .DATA_W     (DATA_W),
   .NUM_REGS   (NUM_REGS),
   .ADDR_W     (ADDR_W),
   .HAS_MODE   (HAS_MODE),
   .MODE_RESET (MODE_RESET)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_we    (bus_we),
   .bus_wdata (bus_wdata),
   .bus_re    (bus_re),
   .bus_rdata (bus_rdata),
   .reg_out   (reg_out),
   .mode_out  (mode_out)
);

// File: tb/sab_regbank_test.sv
`timescale 1ns/1ps
module sab_regbank_test;

   localparam int DW = 32;
   localparam int NR = 4;
   localparam int AW = 14;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [AW-1:0]    bus_addr = '0;
   logic             bus_we = 1'b0;
   logic [DW-1:0]    bus_wdata = '0;
   logic             bus_re = 1'b0;
   logic [DW-1:0]    bus_rdata;
   logic [NR*DW-1:0] reg_out;
   logic [DW-1:0]    mode_out;

   int total = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   sab_regbank uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
      .reg_out(reg_out), .mode_out(mode_out)
   );

   typedef struct packed {
      logic          is_rd;
      logic [AW-1:0] addr;
      logic [DW-1:0] data;   // write data, or expected read data
      logic [3:0]    req;
   } vec_t;

   localparam vec_t VECS [0:28] = '{
      '{1'b0, 14'h000, 32'h0000_00F0, 4'd3},  // R3 set reg0
      '{1'b0, 14'h000, 32'h8000_0001, 4'd3},  // R3 set more bits
      '{1'b1, 14'h008, 32'h8000_00F1, 4'd3},  // R3 readback
      '{1'b0, 14'h004, 32'h0000_0030, 4'd4},  // R4 clear
      '{1'b1, 14'h008, 32'h8000_00C1, 4'd4},  // R4 readback
      '{1'b0, 14'h00C, 32'hFFFF_0000, 4'd3},  // R3 set reg1
      '{1'b0, 14'h010, 32'h0F0F_0000, 4'd4},  // R4 clear reg1
      '{1'b1, 14'h014, 32'hF0F0_0000, 4'd4},  // R4 readback reg1
      '{1'b1, 14'h008, 32'h8000_00C1, 4'd2},  // R2 reg0 untouched
      '{1'b0, 14'h014, 32'h0000_1234, 4'd7},  // R7 write to read alias
      '{1'b1, 14'h014, 32'hF0F0_0000, 4'd7},  // R7 ignored
      '{1'b1, 14'h00C, 32'h0000_0000, 4'd7},  // R7 set alias reads zero
      '{1'b1, 14'h010, 32'h0000_0000, 4'd7},  // R7 clear alias reads zero
      '{1'b0, 14'h024, 32'hA5A5_A5A5, 4'd2},  // R2 reg3 set address
      '{1'b1, 14'h02C, 32'hA5A5_A5A5, 4'd5},  // R5 read reg3
      '{1'b0, 14'h028, 32'h0000_00FF, 4'd4},  // R4 clear reg3
      '{1'b1, 14'h02C, 32'hA5A5_A500, 4'd4},  // R4 readback
      '{1'b0, 14'h030, 32'h0000_1234, 4'd8},  // R8 mode write
      '{1'b0, 14'h030, 32'h0000_0001, 4'd8},  // R8 replace
      '{1'b1, 14'h030, 32'h0000_0001, 4'd8},  // R8 readback
      '{1'b0, 14'h040, 32'hFFFF_FFFF, 4'd9},  // R9 undecoded write
      '{1'b1, 14'h040, 32'h0000_0000, 4'd9},  // R9 undecoded read
      '{1'b0, 14'h001, 32'hFFFF_FFFF, 4'd9},  // R9 misaligned write near reg0 set
      '{1'b1, 14'h008, 32'h8000_00C1, 4'd9},  // R9 reg0 unchanged
      '{1'b0, 14'h018, 32'h0000_0000, 4'd3},  // R3 zero mask set
      '{1'b0, 14'h01C, 32'hFFFF_FFFF, 4'd4},  // R4 clear on zero reg
      '{1'b1, 14'h020, 32'h0000_0000, 4'd3},  // R3 reg2 still zero
      '{1'b1, 14'h3FFC, 32'h0000_0000, 4'd9}, // R9 top of window
      '{1'b1, 14'h00A, 32'h0000_0000, 4'd9}   // R9 misaligned read
   };

   task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic do_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
      @(negedge clk);
      bus_addr = a; bus_re = 1'b1;
      @(negedge clk);
      bus_re = 1'b0;
      d = bus_rdata;
   endtask

   initial begin
      #(8 * 20000);
      if (!done) begin
         total++; fails++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] rd;

      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1 reg_out in reset", reg_out[DW-1:0] | reg_out[2*DW-1:DW] |
            reg_out[3*DW-1:2*DW] | reg_out[4*DW-1:3*DW], '0);
      check("R1 mode_out in reset", mode_out, '0);
      check("R1 rdata in reset", bus_rdata, '0);
      rst_n = 1'b1;

      // Vector walk
      for (int k = 0; k < 29; k++) begin
         if (VECS[k].is_rd) begin
            do_read(VECS[k].addr, rd);
            check($sformatf("R%0d vector %0d addr %h", VECS[k].req, k, VECS[k].addr),
                  rd, VECS[k].data);
         end else begin
            do_write(VECS[k].addr, VECS[k].data);
         end
      end

      // R3 / R4: outputs toward peripheral logic match the model
      check("R3 reg_out reg0", reg_out[0*DW +: DW], 32'h8000_00C1);
      check("R4 reg_out reg1", reg_out[1*DW +: DW], 32'hF0F0_0000);
      check("R3 reg_out reg2", reg_out[2*DW +: DW], 32'h0000_0000);
      check("R4 reg_out reg3", reg_out[3*DW +: DW], 32'hA5A5_A500);
      check("R8 mode_out", mode_out, 32'h0000_0001);

      // R10: idle cycle after a read gives zero
      @(negedge clk);
      check("R10 rdata idle", bus_rdata, '0);

      // R6: write takes effect at the sampling edge
      @(negedge clk);
      bus_addr = 14'h018; bus_wdata = 32'h0000_0004; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
      check("R6 reg2 updated after edge", reg_out[2*DW +: DW], 32'h0000_0004);
      bus_addr = 14'h020; bus_re = 1'b1;
      @(negedge clk);
      bus_re = 1'b0;
      check("R6 back-to-back read", bus_rdata, 32'h0000_0004);

      // R6: read and write in the same cycle returns the old mode value
      @(negedge clk);
      bus_addr = 14'h030; bus_wdata = 32'hCAFE_0000; bus_we = 1'b1; bus_re = 1'b1;
      @(negedge clk);
      bus_we = 1'b0; bus_re = 1'b0;
      check("R6 same-cycle read old value", bus_rdata, 32'h0000_0001);
      check("R8 mode after same-cycle write", mode_out, 32'hCAFE_0000);

      // R1: reset mid-run wipes a populated bank
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 reg0 after reset", reg_out[0*DW +: DW], '0);
      check("R1 reg3 after reset", reg_out[3*DW +: DW], '0);
      check("R1 mode after reset", mode_out, '0);
      rst_n = 1'b1;
      do_read(14'h008, rd);
      check("R1 reg0 readback after reset", rd, '0);

      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

endmodule